// File: doc/BRIEF.md
# Hearing Aid Memory Selector

This block decides which of four stored listening profiles (A, B, C, D, encoded 0 to 3) is active. It reads two wearer switch pins. It synchronises them and finds press edges on the first pin. A configured operating mode then maps the pins to a profile index.

The block drives a 2-bit profile index and a one-clock change strobe. A downstream fader or indicator player uses the strobe to act on each profile switch. Every configuration input is static, except the valid-profile count, the telecoil enable and the power-on hold. Change the pull polarity or the mode only while reset is asserted.

Some configurations let the second pin force profile D. In those, the block can remember the profile that was active before the jump and restore it on release. A telephone-coil option makes the return to the remembered profile wait until the second pin has stayed open for a programmed number of clocks.

Top module: `memsel_top`

## Requirements
- R1: While reset is asserted, `mem_idx` reads 0 (profile A) and `mem_chg` is low.
- R2: In mode 0 (single push button), each press on pin 1 moves to the next profile. After the last valid profile (index `cfg_nvalid`-1) it wraps to 0. A count of 0 acts as 1 and counts above 4 act as 4. With one valid profile the index stays 0.
- R3: A press is the change of pin 1 from its idle level to its active level. Holding the button does not repeat. The active level of both pins is high when `cfg_pullup`=0 and low when `cfg_pullup`=1. The index moves on the third rising clock edge after the pin changes.
- R4: While `por_hold` is 1, presses on pin 1 are ignored in modes 0 and 1.
- R5: In mode 1 (push button plus D switch), pin 2 at its active level forces index 3. This also applies straight after reset. Presses on pin 1 are ignored while pin 2 forces index 3.
- R6: In mode 1, when pin 2 leaves its active level, the index returns to the value it held before the forced jump. While not forced, presses cycle only through indices below min(count, 3).
- R7: In mode 2 (two level switches), the index is {pin2, pin1} as a 2-bit code: pin1 high alone gives 1 and pin2 high alone gives 2. A code at or above the valid count gives 0.
- R8: In mode 3 (level switch plus D switch), pin 2 at its active level gives index 3. Otherwise the index is 1 when pin 1 is high and the count is at least 2, and 0 in all other cases.
- R9: With `cfg_tcoil_en`=1 in modes 1 and 3, index 3 is entered on the same edge as without the option. The release waits until pin 2 has been seen idle on `cfg_hold_cnt` consecutive synchronised samples (hold count of at least 1). Any return to the active level within that window restarts the count.
- R10: With `cfg_sw2_off`=1 in modes 1 and 3, pin 2 never forces index 3.
- R11: `mem_chg` is high for exactly the clock cycles in which `mem_idx` has just taken a new value. This includes forced jumps and restores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw1_pin | input | 1 | Switch pin 1, asynchronous |
| sw2_pin | input | 1 | Switch pin 2, asynchronous |
| cfg_mode | input | 2 | 0 push button, 1 push button + D switch, 2 two level switches, 3 level switch + D switch |
| cfg_nvalid | input | 3 | Number of valid profiles (1 to 4) |
| cfg_pullup | input | 1 | 1 selects active-low switches |
| cfg_sw2_off | input | 1 | Disables forcing by pin 2 |
| cfg_tcoil_en | input | 1 | Enables the delayed release of the D force |
| cfg_hold_cnt | input | HOLD_W | Release window in clock samples |
| por_hold | input | 1 | Power-on delay running, presses ignored |
| mem_idx | output | 2 | Active profile index |
| mem_chg | output | 1 | One-cycle strobe on every index change |

## Verification
The bench builds the block with `HOLD_W` = 8 and release windows of 1 and 10 samples. These short windows let it check the exact release edge, both one cycle early and on time, and let it restart the window with a short bounce. Both pull polarities are reset into place so that the active-low forms of the start-up force and the level-switch tables are exercised. Random switch patterns and valid counts run against bench functions for the level-switch modes and the push-button wrap.

// File: rtl/memsel_pkg.sv
// Shared types and helpers for the profile selector.
// Assumes a profile index of two bits (four profiles).
package memsel_pkg;
    typedef enum logic [1:0] {
        SEL_MOMENTARY    = 2'd0,
        SEL_MOM_DONLY    = 2'd1,
        SEL_STATIC_PAIR  = 2'd2,
        SEL_STATIC_DONLY = 2'd3
    } sel_mode_e;

    localparam logic [1:0] PROF_A = 2'd0;
    localparam logic [1:0] PROF_B = 2'd1;
    localparam logic [1:0] PROF_D = 2'd3;

    // Clip a configured profile count into the range 1..4.
    function automatic logic [2:0] clip_count(input logic [2:0] n);
        if (n == 3'd0)
            return 3'd1;
        else if (n > 3'd4)
            return 3'd4;
        else
            return n;
    endfunction
endpackage

// File: rtl/memsel_sync.sv
// Two-flop synchroniser for W asynchronous pins.
// Assumes rst_val holds the idle level, so reset creates no edge.
module memsel_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages per pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= rst_val;
            q      <= rst_val;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/memsel_release.sv
// Stretches the release of an active-high force request.
// When enabled, the output follows the request's rise at once and falls
// only after 'period' consecutive idle samples. Assumes period >= 1.
module memsel_release #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          act,
    input  logic [CW-1:0] period,
    output logic          force_o
);
    localparam int EW = CW + 1;

    logic          held_q;
    logic [CW-1:0] cnt_q;
    logic [EW-1:0] cnt_next;

    assign cnt_next = {1'b0, cnt_q} + EW'(1);

    // Track the idle run length while the stretched force is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!en) begin
            held_q <= 1'b0;
            cnt_q  <= '0;
        end else if (act) begin
            held_q <= 1'b1;
            cnt_q  <= '0;
        end else if (held_q) begin
            if (cnt_next >= {1'b0, period}) begin
                held_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_next[CW-1:0];
            end
        end
    end

    assign force_o = act | (en & held_q);
endmodule

// File: rtl/memsel_core.sv
// Mode logic: computes the next profile index from synchronised pin
// levels, the press pulse and the D force, and keeps the remembered profile
// for restore. Assumes nv is already clipped to 1..4.
module memsel_core
    import memsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic [2:0] nv,
    input  logic       press,
    input  logic       hold,
    input  logic       lvl1,
    input  logic       lvl2,
    input  logic       force_d,
    output logic [1:0] idx,
    output logic       chg
);
    logic [1:0] cur_q, saved_q, nxt;
    logic       forced_q;
    logic [2:0] lim3;
    logic [2:0] code;
    logic       adv;

    // Advance with wrap inside the first 'lim' profiles.
    function automatic logic [1:0] step(input logic [1:0] c, input logic [2:0] lim);
        if (({1'b0, c} + 3'd1) >= lim)
            return PROF_A;
        else
            return c + 2'd1;
    endfunction

    // Next-index selection per mode.
    always_comb begin
        adv  = press & ~hold;
        lim3 = (nv > 3'd3) ? 3'd3 : nv;
        code = {1'b0, lvl2, lvl1};
        nxt  = cur_q;
        case (mode)
            SEL_MOMENTARY: begin
                if ({1'b0, cur_q} >= nv)
                    nxt = PROF_A;
                else if (adv)
                    nxt = step(cur_q, nv);
            end
            SEL_MOM_DONLY: begin
                if (force_d)
                    nxt = PROF_D;
                else if (forced_q)
                    nxt = ({1'b0, saved_q} < lim3) ? saved_q : PROF_A;
                else if ({1'b0, cur_q} >= lim3)
                    nxt = PROF_A;
                else if (adv)
                    nxt = step(cur_q, lim3);
            end
            SEL_STATIC_PAIR: begin
                nxt = (code < nv) ? code[1:0] : PROF_A;
            end
            default: begin
                if (force_d)
                    nxt = PROF_D;
                else if (lvl1 && nv >= 3'd2)
                    nxt = PROF_B;
                else
                    nxt = PROF_A;
            end
        endcase
    end

    // Index, strobe, force flag and remembered profile registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= PROF_A;
            saved_q  <= PROF_A;
            forced_q <= 1'b0;
            chg      <= 1'b0;
        end else begin
            cur_q    <= nxt;
            chg      <= (nxt != cur_q);
            forced_q <= (mode == SEL_MOM_DONLY) && force_d;
            if ((mode == SEL_MOM_DONLY) && force_d && !forced_q)
                saved_q <= cur_q;
        end
    end

    assign idx = cur_q;
endmodule

// File: rtl/memsel_top.sv
// Profile selector top: synchronises the switch pins, normalises their
// polarity, detects pin-1 presses, gates the D request and drives the core.
// Assumes cfg_mode and cfg_pullup change only under reset.
module memsel_top
    import memsel_pkg::*;
#(
    parameter int HOLD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw1_pin,
    input  logic              sw2_pin,
    input  logic [1:0]        cfg_mode,
    input  logic [2:0]        cfg_nvalid,
    input  logic              cfg_pullup,
    input  logic              cfg_sw2_off,
    input  logic              cfg_tcoil_en,
    input  logic [HOLD_W-1:0] cfg_hold_cnt,
    input  logic              por_hold,
    output logic [1:0]        mem_idx,
    output logic              mem_chg
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pins_s;
    logic            act1, act2, act1_prev_q, press;
    logic            d_req, force_d;
    logic            donly_mode;

    memsel_sync #(.W(NPIN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val ({NPIN{cfg_pullup}}),
        .d       ({sw2_pin, sw1_pin}),
        .q       (pins_s)
    );

    assign act1       = pins_s[0] ^ cfg_pullup;
    assign act2       = pins_s[1] ^ cfg_pullup;
    assign donly_mode = (cfg_mode == SEL_MOM_DONLY) || (cfg_mode == SEL_STATIC_DONLY);
    assign d_req      = act2 & ~cfg_sw2_off & donly_mode;

    // Remember the last active state of pin 1 for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act1_prev_q <= 1'b1;
        else
            act1_prev_q <= act1;
    end

    assign press = act1 & ~act1_prev_q;

    memsel_release #(.CW(HOLD_W)) u_release (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_tcoil_en),
        .act     (d_req),
        .period  (cfg_hold_cnt),
        .force_o (force_d)
    );

    memsel_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (cfg_mode),
        .nv      (clip_count(cfg_nvalid)),
        .press   (press),
        .hold    (por_hold),
        .lvl1    (pins_s[0]),
        .lvl2    (pins_s[1]),
        .force_d (force_d),
        .idx     (mem_idx),
        .chg     (mem_chg)
    );
endmodule

// File: rtl/memsel_chk.sv
// Property checker for the profile selector, bound into memsel_top.
module memsel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       por_hold,
    input logic       force_d,
    input logic [1:0] mem_idx,
    input logic       mem_chg
);
    AST_STROBE_MATCHES_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_chg == (mem_idx != $past(mem_idx))); // R11

    AST_HOLD_BLOCKS_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (por_hold && cfg_mode == 2'd0) |=> $stable(mem_idx)); // R4

    AST_FORCE_GIVES_D: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && force_d) |=> (mem_idx == 2'd3)); // R5

    AST_UNFORCED_SKIPS_D: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && !force_d) |=> (mem_idx != 2'd3)); // R6

    AST_D_ONLY_LEVEL_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3 && force_d) |=> (mem_idx == 2'd3)); // R8
endmodule

bind memsel_top memsel_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .por_hold (por_hold),
    .force_d  (force_d),
    .mem_idx  (mem_idx),
    .mem_chg  (mem_chg)
);

// File: tb/sim_memsel_top.sv
module sim_memsel_top;
    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw1_pin = 1'b0, sw2_pin = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [2:0]    cfg_nvalid = 3'd4;
    logic          cfg_pullup = 1'b0, cfg_sw2_off = 1'b0, cfg_tcoil_en = 1'b0;
    logic [HW-1:0] cfg_hold_cnt = 8'd1;
    logic          por_hold = 1'b0;
    logic [1:0]    mem_idx;
    logic          mem_chg;

    int errors = 0, checks = 0;
    int n_strobe = 0, n_move = 0;
    logic [1:0] last_idx = 2'd0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    memsel_top #(.HOLD_W(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .sw1_pin(sw1_pin), .sw2_pin(sw2_pin),
        .cfg_mode(cfg_mode), .cfg_nvalid(cfg_nvalid), .cfg_pullup(cfg_pullup),
        .cfg_sw2_off(cfg_sw2_off), .cfg_tcoil_en(cfg_tcoil_en),
        .cfg_hold_cnt(cfg_hold_cnt), .por_hold(por_hold),
        .mem_idx(mem_idx), .mem_chg(mem_chg));

    // Count strobes and observed index moves (R11).
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_chg) n_strobe++;
            if (mem_idx != last_idx) n_move++;
        end
        last_idx = mem_idx;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input logic [1:0] m, input logic pu, input logic p1, input logic p2);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_mode = m; cfg_pullup = pu; sw1_pin = p1; sw2_pin = p2;
        cyc(3);
        rst_n = 1'b1;
        cyc(6);
    endtask

    task automatic press1();
        sw1_pin = ~cfg_pullup;
        cyc(4);
        sw1_pin = cfg_pullup;
        cyc(4);
    endtask

    function automatic int wrap_next(int c, int nv);
        return (c + 1 >= nv) ? 0 : c + 1;
    endfunction

    function automatic int exp_pair(logic p1, logic p2, int nv);
        int code = {p2, p1};
        return (code < nv) ? code : 0;
    endfunction

    function automatic int exp_donly(logic p1, logic p2, logic pu, int nv);
        if (p2 ^ pu) return 3;
        return (p1 && nv >= 2) ? 1 : 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int e;
        int s0;
        void'($urandom(1234));
        // R1 reset state
        cyc(2);
        chk("R1 idx in reset", mem_idx, 0);
        chk("R1 strobe in reset", mem_chg, 0);
        rst_n = 1'b1;
        cyc(6);

        // R2 push-button cycle with wrap
        e = 0;
        for (int i = 0; i < 5; i++) begin
            press1();
            e = wrap_next(e, 4);
            chk("R2 advance", mem_idx, e);
        end
        // R3 held button advances once; latency of three edges
        sw1_pin = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R3 not yet moved", mem_idx, e);
        @(negedge clk);
        e = wrap_next(e, 4);
        chk("R3 third edge", mem_idx, e);
        cyc(20);
        chk("R3 hold no repeat", mem_idx, e);
        sw1_pin = 1'b0;
        cyc(4);

        // R2 one valid profile
        cfg_nvalid = 3'd1;
        cyc(3);
        for (int i = 0; i < 3; i++) press1();
        chk("R2 single valid", mem_idx, 0);

        // R4 power-on hold
        cfg_nvalid = 3'd3;
        por_hold = 1'b1;
        press1(); press1();
        chk("R4 hold ignores", mem_idx, 0);
        por_hold = 1'b0;
        press1();
        chk("R4 after hold", mem_idx, 1);

        // R3 active-low press, random push-button sequence (R2)
        restart(2'd0, 1'b1, 1'b1, 1'b1);
        chk("R3 pullup no false press", mem_idx, 0);
        e = 0;
        for (int i = 0; i < 20; i++) begin
            int nv = 1 + int'($urandom_range(3));
            cfg_nvalid = 3'(nv);
            cyc(2);
            if (e >= nv) e = 0;
            press1();
            e = wrap_next(e, nv);
            chk("R2 random advance", mem_idx, e);
        end

        // R5/R6 mode 1 active-high
        cfg_nvalid = 3'd4;
        restart(2'd1, 1'b0, 1'b0, 1'b0);
        press1();
        chk("R6 start cycle", mem_idx, 1);
        s0 = n_strobe;
        sw2_pin = 1'b1;
        cyc(5);
        chk("R5 forced D", mem_idx, 3);
        chk("R11 one strobe on jump", n_strobe - s0, 1);
        press1(); press1();
        chk("R5 presses ignored", mem_idx, 3);
        sw2_pin = 1'b0;
        cyc(5);
        chk("R6 restore", mem_idx, 1);
        press1();
        chk("R6 next C", mem_idx, 2);
        press1();
        chk("R6 D skipped", mem_idx, 0);

        // R5 start-up force, active-low
        restart(2'd1, 1'b1, 1'b1, 1'b0);
        chk("R5 startup D pullup", mem_idx, 3);
        sw2_pin = 1'b1;
        cyc(5);
        chk("R6 restore to A", mem_idx, 0);

        // R7 two level switches, random
        restart(2'd2, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) begin
            logic a, b;
            int nv;
            a = 1'($urandom_range(1));
            b = 1'($urandom_range(1));
            nv = 1 + int'($urandom_range(3));
            sw1_pin = a; sw2_pin = b; cfg_nvalid = 3'(nv);
            cyc(5);
            chk("R7 level code", mem_idx, exp_pair(a, b, nv));
        end

        // R8 level switch + D switch, both polarities
        for (int pu = 0; pu < 2; pu++) begin
            restart(2'd3, 1'(pu), 1'b0, 1'(pu));
            for (int i = 0; i < 20; i++) begin
                logic a, b;
                int nv;
                a = 1'($urandom_range(1));
                b = 1'($urandom_range(1));
                nv = 1 + int'($urandom_range(3));
                sw1_pin = a; sw2_pin = b; cfg_nvalid = 3'(nv);
                cyc(5);
                chk("R8 D-only table", mem_idx, exp_donly(a, b, 1'(pu), nv));
            end
        end

        // R10 pin 2 disabled
        cfg_sw2_off = 1'b1;
        cfg_nvalid = 3'd4;
        sw2_pin = 1'b0; sw1_pin = 1'b1;
        cyc(5);
        chk("R10 D blocked mode 3", mem_idx, 1);
        restart(2'd1, 1'b0, 1'b0, 1'b1);
        chk("R10 D blocked mode 1", mem_idx, 0);
        cfg_sw2_off = 1'b0;

        // R9 delayed release with window 10
        cfg_tcoil_en = 1'b1;
        cfg_hold_cnt = 8'd10;
        restart(2'd1, 1'b0, 1'b0, 1'b0);
        press1();
        sw2_pin = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 entry not early", mem_idx, 1);
        @(negedge clk);
        chk("R9 entry immediate", mem_idx, 3);
        cyc(4);
        sw2_pin = 1'b0;
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk("R9 held through window", mem_idx, 3);
        @(negedge clk);
        chk("R9 released after window", mem_idx, 1);
        // bounce restarts the window
        sw2_pin = 1'b1; cyc(4);
        sw2_pin = 1'b0; cyc(5);
        sw2_pin = 1'b1; cyc(2);
        sw2_pin = 1'b0;
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk("R9 bounce restarts", mem_idx, 3);
        @(negedge clk);
        chk("R9 release after bounce", mem_idx, 1);
        // window of one sample in mode 3
        cfg_hold_cnt = 8'd1;
        restart(2'd3, 1'b0, 1'b0, 1'b1);
        chk("R9 mode 3 entry", mem_idx, 3);
        sw2_pin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 one-sample hold", mem_idx, 3);
        @(negedge clk);
        chk("R9 one-sample release", mem_idx, 0);
        cfg_tcoil_en = 1'b0;

        cyc(4);
        chk("R11 strobes equal moves", n_strobe, n_move);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule